// File: doc/BRIEF.md
# Multithreaded Reorder Buffer Core

This block keeps the in-flight instructions of several hardware threads in one shared reorder buffer. Every thread owns a private in-order queue, realised as a circular buffer. Each entry holds a 32-bit sequence number, a program counter, the following program counter, a ready-to-commit flag and a squashed flag. The allocate port supplies all five fields. Allocation appends to the queue of the named thread. Retirement removes the front entry of one thread. The caller names that thread directly, or asks for the thread that owns the global head.

Two entries are derived from the queue fronts and backs on every cycle. The global head is the oldest front entry, the one with the lowest sequence number. The global tail is the youngest back entry, the one with the highest sequence number. Both look only at threads enabled in the active mask. A read port shows the head, the tail and the count of any one thread. Any head or tail read of an empty view returns an all-zero dummy entry with its valid bit low. A total counter drives the occupancy, free-entry and full outputs. The capacity sharing policy and the squash walk live in other blocks and are not part of this core.

Top module: `rob_mt_core`

## Requirements
- R1: An accepted allocation (al_valid high, full low, al_tid below NT) appends the entry behind the back of thread al_tid's queue. It raises total_count by one and that thread's count by one on the next clock edge.
- R2: full is high exactly when total_count equals CAP. An allocation presented while full is high is dropped: the counts, the queues and the global tail stay unchanged.
- R3: An allocation into an empty buffer makes the new entry the global head from the next cycle, provided its thread is active.
- R4: A retire request fires (rt_fire high in the same cycle) only when the target thread's queue is non-empty and its front entry has the ready flag set. On the next edge that front entry is removed and both counts drop by one. A request against an empty or not-ready front has no effect.
- R5: The global head, with ghead_valid, is the front entry with the lowest sequence number among non-empty queues of threads whose act_mask bit is 1. Equal sequence numbers resolve to the lower thread index. ghead_tid names the owning thread.
- R6: The global tail, with gtail_valid, is the back entry with the highest sequence number among non-empty queues of active threads. The per-thread tail on the read port is the back of thread rd_tid.
- R7: head_ready is 0 when no global head exists and otherwise equals the head's ready flag. th_head_rdy follows the same rule for thread rd_tid.
- R8: can_commit is high when at least one active thread has a non-empty queue whose front is ready.
- R9: free_count equals CAP minus total_count. th_count gives the number of entries held by thread rd_tid.
- R10: A head or tail view with no valid entry shows sequence number, program counters and flags all 0.
- R11: An allocation and a retire in the same cycle both take effect and total_count is unchanged. Acceptance of the allocation is judged on the count before the retire, so at full the allocation is dropped even though a retire fires.
- R12: With rt_global high the retire targets the thread that owns the global head and needs a valid, ready head. With rt_global low it targets thread rt_tid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_mask | input | NT | Active-thread enable per thread |
| al_valid | input | 1 | Allocation request |
| al_tid | input | TW | Thread of the allocated entry |
| al_seq | input | 32 | Sequence number of the entry |
| al_pc | input | 32 | Program counter of the entry |
| al_npc | input | 32 | Next program counter of the entry |
| al_rdy | input | 1 | Ready-to-commit flag of the entry |
| al_sq | input | 1 | Squashed flag of the entry |
| full | output | 1 | Total count equals capacity |
| rt_valid | input | 1 | Retire request |
| rt_global | input | 1 | 1: retire the global head's thread, 0: retire rt_tid |
| rt_tid | input | TW | Thread for a per-thread retire |
| rt_fire | output | 1 | Retire accepted this cycle |
| ghead_valid | output | 1 | Global head exists |
| ghead_tid | output | TW | Thread owning the global head |
| ghead_seq | output | 32 | Global head sequence number |
| ghead_pc | output | 32 | Global head program counter |
| ghead_npc | output | 32 | Global head next program counter |
| ghead_rdy | output | 1 | Global head ready flag |
| ghead_sq | output | 1 | Global head squashed flag |
| gtail_valid | output | 1 | Global tail exists |
| gtail_tid | output | TW | Thread owning the global tail |
| gtail_seq | output | 32 | Global tail sequence number |
| gtail_pc | output | 32 | Global tail program counter |
| gtail_npc | output | 32 | Global tail next program counter |
| head_ready | output | 1 | Global head is ready to commit |
| can_commit | output | 1 | Some active thread has a ready front |
| rd_tid | input | TW | Thread shown on the per-thread read port |
| th_head_valid | output | 1 | Thread rd_tid has entries |
| th_head_seq | output | 32 | Front sequence number of thread rd_tid |
| th_head_pc | output | 32 | Front program counter of thread rd_tid |
| th_head_npc | output | 32 | Front next program counter of thread rd_tid |
| th_head_rdy | output | 1 | Front ready flag of thread rd_tid |
| th_head_sq | output | 1 | Front squashed flag of thread rd_tid |
| th_tail_seq | output | 32 | Back sequence number of thread rd_tid |
| th_tail_pc | output | 32 | Back program counter of thread rd_tid |
| th_count | output | CW | Entries held by thread rd_tid |
| total_count | output | CW | Entries held in total |
| free_count | output | CW | CAP minus total_count |

## Verification
Allocation and retirement can land on the same clock edge, and their interaction is where the counter and the full decision are most fragile. The bench provokes this twice in directed form. The first case is partway full, where both actions must take effect and the total must stay put. The second case is exactly full, where the retire fires but the allocation must still be refused because fullness is judged before the retire. A long pseudo-random phase then mixes allocate, global retire and per-thread retire under changing active masks. A queue model in the bench predicts rt_fire, the counts and the head and tail views every cycle.

// File: rtl/rob_mt_pkg.sv
package rob_mt_pkg;

    localparam int SEQ_W = 32;
    localparam int PC_W  = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        seq_t seq;
        pc_t  pc;
        pc_t  npc;
        logic rdy;
        logic sq;
    } rob_entry_t;

    // age comparison used by the head/tail pickers
    function automatic logic seq_before(input seq_t a, input seq_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/rob_mt_tq.sv
module rob_mt_tq
    import rob_mt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  rob_entry_t      push_data,
    input  logic            pop,
    output logic [CW-1:0]   count,
    output rob_entry_t      front,
    output rob_entry_t      back
);

    rob_entry_t     slots [DEPTH];
    logic [AW-1:0]  rd_ptr;
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  last_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_comb begin
        front = '0;
        back  = '0;
        if (count != '0) begin
            front = slots[rd_ptr];
            back  = slots[last_ptr];
        end
    end

endmodule

// File: rtl/rob_mt_agesel.sv
module rob_mt_agesel
    import rob_mt_pkg::*;
#(
    parameter int NT       = 2,
    parameter bit PICK_OLD = 1'b1,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0]   cand,
    input  seq_t            key [NT],
    output logic            found,
    output logic [TW-1:0]   idx
);

    seq_t best;
    logic better [NT];

    // the comparison direction is chosen at elaboration
    for (genvar t = 0; t < NT; t++) begin : g_cmp
        if (PICK_OLD) begin : g_old
            assign better[t] = seq_before(key[t], best_at[t]);
        end else begin : g_young
            assign better[t] = seq_before(best_at[t], key[t]);
        end
    end

    seq_t best_at [NT];
    logic found_at [NT];

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int t = 0; t < NT; t++) begin
            best_at[t]  = best;
            found_at[t] = found;
            if (cand[t] && (!found || better[t])) begin
                found = 1'b1;
                idx   = TW'(t);
                best  = key[t];
            end
        end
    end

endmodule

// File: rtl/rob_mt_core.sv
module rob_mt_core
    import rob_mt_pkg::*;
#(
    parameter int NT  = 2,
    parameter int CAP = 8,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NT-1:0]   act_mask,
    input  logic            al_valid,
    input  logic [TW-1:0]   al_tid,
    input  logic [31:0]     al_seq,
    input  logic [31:0]     al_pc,
    input  logic [31:0]     al_npc,
    input  logic            al_rdy,
    input  logic            al_sq,
    output logic            full,
    input  logic            rt_valid,
    input  logic            rt_global,
    input  logic [TW-1:0]   rt_tid,
    output logic            rt_fire,
    output logic            ghead_valid,
    output logic [TW-1:0]   ghead_tid,
    output logic [31:0]     ghead_seq,
    output logic [31:0]     ghead_pc,
    output logic [31:0]     ghead_npc,
    output logic            ghead_rdy,
    output logic            ghead_sq,
    output logic            gtail_valid,
    output logic [TW-1:0]   gtail_tid,
    output logic [31:0]     gtail_seq,
    output logic [31:0]     gtail_pc,
    output logic [31:0]     gtail_npc,
    output logic            head_ready,
    output logic            can_commit,
    input  logic [TW-1:0]   rd_tid,
    output logic            th_head_valid,
    output logic [31:0]     th_head_seq,
    output logic [31:0]     th_head_pc,
    output logic [31:0]     th_head_npc,
    output logic            th_head_rdy,
    output logic            th_head_sq,
    output logic [31:0]     th_tail_seq,
    output logic [31:0]     th_tail_pc,
    output logic [CW-1:0]   th_count,
    output logic [CW-1:0]   total_count,
    output logic [CW-1:0]   free_count
);

    rob_entry_t     q_front [NT];
    rob_entry_t     q_back  [NT];
    logic [CW-1:0]  q_count [NT];
    seq_t           front_key [NT];
    seq_t           back_key  [NT];
    logic [NT-1:0]  q_push;
    logic [NT-1:0]  q_pop;
    logic [NT-1:0]  q_busy;
    logic [NT-1:0]  q_rdy;
    logic [NT-1:0]  cand;

    rob_entry_t     new_entry;
    logic           al_ok;
    logic           al_tid_ok;
    logic           rt_tid_ok;
    logic [TW-1:0]  rt_target;
    logic [TW-1:0]  h_idx;
    logic [TW-1:0]  t_idx;
    logic           h_found;
    logic           t_found;
    rob_entry_t     h_ent;
    rob_entry_t     t_ent;
    rob_entry_t     rd_front;
    rob_entry_t     rd_back;
    logic [CW-1:0]  tot_q;

    assign new_entry = '{seq: al_seq, pc: al_pc, npc: al_npc, rdy: al_rdy, sq: al_sq};
    assign al_tid_ok = (int'(al_tid) < NT);
    assign rt_tid_ok = (int'(rt_tid) < NT);
    assign full      = (tot_q == CW'(CAP));
    assign al_ok     = al_valid && !full && al_tid_ok;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        rob_mt_tq #(.DEPTH(CAP)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (q_push[t]),
            .push_data (new_entry),
            .pop       (q_pop[t]),
            .count     (q_count[t]),
            .front     (q_front[t]),
            .back      (q_back[t])
        );
        assign q_push[t]    = al_ok && (al_tid == TW'(t));
        assign q_pop[t]     = rt_fire && (rt_target == TW'(t));
        assign q_busy[t]    = (q_count[t] != '0);
        assign q_rdy[t]     = q_front[t].rdy;
        assign front_key[t] = q_front[t].seq;
        assign back_key[t]  = q_back[t].seq;
    end

    assign cand = q_busy & act_mask;

    rob_mt_agesel #(.NT(NT), .PICK_OLD(1'b1)) u_head_sel (
        .cand  (cand),
        .key   (front_key),
        .found (h_found),
        .idx   (h_idx)
    );

    rob_mt_agesel #(.NT(NT), .PICK_OLD(1'b0)) u_tail_sel (
        .cand  (cand),
        .key   (back_key),
        .found (t_found),
        .idx   (t_idx)
    );

    assign h_ent = h_found ? q_front[h_idx] : '0;
    assign t_ent = t_found ? q_back[t_idx]  : '0;

    // retire target and acceptance
    always_comb begin
        rt_target = rt_global ? h_idx : rt_tid;
        if (rt_global) begin
            rt_fire = rt_valid && h_found && h_ent.rdy;
        end else begin
            rt_fire = rt_valid && rt_tid_ok && q_busy[rt_tid] && q_front[rt_tid].rdy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
        end else begin
            tot_q <= tot_q + CW'(al_ok) - CW'(rt_fire);
        end
    end

    assign rd_front = q_front[rd_tid];
    assign rd_back  = q_back[rd_tid];

    assign ghead_valid = h_found;
    assign ghead_tid   = h_found ? h_idx : '0;
    assign ghead_seq   = h_ent.seq;
    assign ghead_pc    = h_ent.pc;
    assign ghead_npc   = h_ent.npc;
    assign ghead_rdy   = h_ent.rdy;
    assign ghead_sq    = h_ent.sq;

    assign gtail_valid = t_found;
    assign gtail_tid   = t_found ? t_idx : '0;
    assign gtail_seq   = t_ent.seq;
    assign gtail_pc    = t_ent.pc;
    assign gtail_npc   = t_ent.npc;

    assign head_ready = h_found && h_ent.rdy;
    assign can_commit = |(cand & q_rdy);

    assign th_head_valid = q_busy[rd_tid];
    assign th_head_seq   = rd_front.seq;
    assign th_head_pc    = rd_front.pc;
    assign th_head_npc   = rd_front.npc;
    assign th_head_rdy   = q_busy[rd_tid] && rd_front.rdy;
    assign th_head_sq    = rd_front.sq;
    assign th_tail_seq   = rd_back.seq;
    assign th_tail_pc    = rd_back.pc;
    assign th_count      = q_count[rd_tid];

    assign total_count = tot_q;
    assign free_count  = CW'(CAP) - tot_q;

endmodule

// File: rtl/rob_mt_core_chk.sv
module rob_mt_core_chk #(
    parameter int NT  = 2,
    parameter int CAP = 8,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1,
    localparam int CW = $clog2(CAP + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            al_valid,
    input logic [TW-1:0]   al_tid,
    input logic            full,
    input logic            rt_fire,
    input logic            ghead_valid,
    input logic [31:0]     ghead_seq,
    input logic            gtail_valid,
    input logic [31:0]     gtail_seq,
    input logic            head_ready,
    input logic            can_commit,
    input logic [CW-1:0]   total_count
);

    logic acc;
    assign acc = al_valid && !full && (int'(al_tid) < NT);

    p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && !rt_fire) |=> (total_count == $past(total_count) + 1'b1));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        total_count <= CW'(CAP));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (full && !rt_fire) |=> (total_count == CW'(CAP)));

    p_retire_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (rt_fire && !acc) |=> (total_count == $past(total_count) - 1'b1));

    p_head_not_younger_r6: assert property (@(posedge clk) disable iff (rst)
        (ghead_valid && gtail_valid) |-> (ghead_seq <= gtail_seq));

    p_ready_implies_commit_r8: assert property (@(posedge clk) disable iff (rst)
        head_ready |-> can_commit);

    p_empty_dummy_r10: assert property (@(posedge clk) disable iff (rst)
        (total_count == '0) |-> (!ghead_valid && !gtail_valid && ghead_seq == '0));

    p_both_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (acc && rt_fire) |=> (total_count == $past(total_count)));

endmodule

bind rob_mt_core rob_mt_core_chk #(.NT(NT), .CAP(CAP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .al_valid    (al_valid),
    .al_tid      (al_tid),
    .full        (full),
    .rt_fire     (rt_fire),
    .ghead_valid (ghead_valid),
    .ghead_seq   (ghead_seq),
    .gtail_valid (gtail_valid),
    .gtail_seq   (gtail_seq),
    .head_ready  (head_ready),
    .can_commit  (can_commit),
    .total_count (total_count)
);

// File: tb/rob_mt_core_tb_top.sv
module rob_mt_core_tb_top;

    localparam int NT  = 2;
    localparam int CAP = 8;
    localparam int TW  = 1;
    localparam int CW  = $clog2(CAP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0] act_mask = '1;
    logic al_valid = 0, al_rdy = 0, al_sq = 0;
    logic [TW-1:0] al_tid = '0;
    logic [31:0] al_seq = '0, al_pc = '0, al_npc = '0;
    logic rt_valid = 0, rt_global = 0;
    logic [TW-1:0] rt_tid = '0;
    logic [TW-1:0] rd_tid = '0;

    logic full, rt_fire, ghead_valid, ghead_rdy, ghead_sq, gtail_valid;
    logic [TW-1:0] ghead_tid, gtail_tid;
    logic [31:0] ghead_seq, ghead_pc, ghead_npc, gtail_seq, gtail_pc, gtail_npc;
    logic head_ready, can_commit, th_head_valid, th_head_rdy, th_head_sq;
    logic [31:0] th_head_seq, th_head_pc, th_head_npc, th_tail_seq, th_tail_pc;
    logic [CW-1:0] th_count, total_count, free_count;

    always #10 clk = ~clk;

    rob_mt_core #(.NT(NT), .CAP(CAP)) dut_i (
        .clk(clk), .rst(rst), .act_mask(act_mask),
        .al_valid(al_valid), .al_tid(al_tid), .al_seq(al_seq), .al_pc(al_pc),
        .al_npc(al_npc), .al_rdy(al_rdy), .al_sq(al_sq), .full(full),
        .rt_valid(rt_valid), .rt_global(rt_global), .rt_tid(rt_tid), .rt_fire(rt_fire),
        .ghead_valid(ghead_valid), .ghead_tid(ghead_tid), .ghead_seq(ghead_seq),
        .ghead_pc(ghead_pc), .ghead_npc(ghead_npc), .ghead_rdy(ghead_rdy), .ghead_sq(ghead_sq),
        .gtail_valid(gtail_valid), .gtail_tid(gtail_tid), .gtail_seq(gtail_seq),
        .gtail_pc(gtail_pc), .gtail_npc(gtail_npc),
        .head_ready(head_ready), .can_commit(can_commit), .rd_tid(rd_tid),
        .th_head_valid(th_head_valid), .th_head_seq(th_head_seq), .th_head_pc(th_head_pc),
        .th_head_npc(th_head_npc), .th_head_rdy(th_head_rdy), .th_head_sq(th_head_sq),
        .th_tail_seq(th_tail_seq), .th_tail_pc(th_tail_pc), .th_count(th_count),
        .total_count(total_count), .free_count(free_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int unsigned seq_ctr = 1;
    int unsigned rng = 32'h1234_5678;

    int unsigned m_seq [NT][$];
    bit          m_rdy [NT][$];

    function automatic int unsigned pc_of(input int unsigned s);
        return 32'h1000 + s * 4;
    endfunction

    function automatic int unsigned rnd();
        rng = rng * 1103515245 + 12345;
        return rng >> 8;
    endfunction

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int total_m();
        int s = 0;
        for (int t = 0; t < NT; t++) s += m_seq[t].size();
        return s;
    endfunction

    task automatic model_head(output bit hv, output int ht, output int unsigned hs);
        hv = 0; ht = 0; hs = 0;
        for (int t = 0; t < NT; t++)
            if (act_mask[t] && m_seq[t].size() > 0 && (!hv || m_seq[t][0] < hs)) begin
                hv = 1; ht = t; hs = m_seq[t][0];
            end
    endtask

    task automatic check_state();
        bit hv, tv, cc;
        int ht, tt, tot, r, n;
        int unsigned hs, ts;
        tot = total_m();
        model_head(hv, ht, hs);
        tv = 0; tt = 0; ts = 0;
        for (int t = 0; t < NT; t++)
            if (act_mask[t] && m_seq[t].size() > 0 && (!tv || m_seq[t][$] > ts)) begin
                tv = 1; tt = t; ts = m_seq[t][$];
            end
        chk("R1", "total_count", total_count, tot);
        chk("R9", "free_count", free_count, CAP - tot);
        chk("R2", "full", full, tot == CAP);
        chk("R5", "ghead_valid", ghead_valid, hv);
        if (hv) begin
            chk("R5", "ghead_seq", ghead_seq, hs);
            chk("R5", "ghead_tid", ghead_tid, ht);
            chk("R5", "ghead_pc", ghead_pc, pc_of(hs));
            chk("R5", "ghead_npc", ghead_npc, pc_of(hs) + 4);
            chk("R5", "ghead_sq", ghead_sq, hs & 1);
        end else begin
            chk("R10", "ghead_seq dummy", ghead_seq, 0);
            chk("R10", "ghead_pc dummy", ghead_pc, 0);
        end
        chk("R6", "gtail_valid", gtail_valid, tv);
        if (tv) begin
            chk("R6", "gtail_seq", gtail_seq, ts);
            chk("R6", "gtail_tid", gtail_tid, tt);
            chk("R6", "gtail_npc", gtail_npc, pc_of(ts) + 4);
        end else begin
            chk("R10", "gtail_seq dummy", gtail_seq, 0);
        end
        chk("R7", "head_ready", head_ready, hv && m_rdy[ht][0]);
        cc = 0;
        for (int t = 0; t < NT; t++)
            if (act_mask[t] && m_seq[t].size() > 0 && m_rdy[t][0]) cc = 1;
        chk("R8", "can_commit", can_commit, cc);
        r = int'(rd_tid);
        n = m_seq[r].size();
        chk("R9", "th_count", th_count, n);
        chk("R7", "th_head_valid", th_head_valid, n > 0);
        if (n > 0) begin
            chk("R7", "th_head_rdy", th_head_rdy, m_rdy[r][0]);
            chk("R5", "th_head_seq", th_head_seq, m_seq[r][0]);
            chk("R6", "th_tail_seq", th_tail_seq, m_seq[r][$]);
            chk("R6", "th_tail_pc", th_tail_pc, pc_of(m_seq[r][$]));
        end else begin
            chk("R10", "th_head_seq dummy", th_head_seq, 0);
            chk("R10", "th_head_rdy dummy", th_head_rdy, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; al_valid = 0; rt_valid = 0;
        for (int t = 0; t < NT; t++) begin m_seq[t].delete(); m_rdy[t].delete(); end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_state();
    endtask

    task automatic step(input bit av, input int at, input bit ardy,
                        input bit rv, input bit rg, input int rt);
        bit acc, fire, hv;
        int ht, tgt;
        int unsigned hs;
        @(negedge clk);
        al_valid = av; al_tid = TW'(at); al_seq = seq_ctr;
        al_pc = pc_of(seq_ctr); al_npc = pc_of(seq_ctr) + 4;
        al_rdy = ardy; al_sq = seq_ctr[0];
        rt_valid = rv; rt_global = rg; rt_tid = TW'(rt);
        #1;
        acc = av && (total_m() < CAP);
        model_head(hv, ht, hs);
        tgt = rg ? ht : rt;
        fire = rv && (rg ? hv : 1'b1) && m_seq[tgt].size() > 0 && m_rdy[tgt][0];
        if (rg) chk("R12", "rt_fire global", rt_fire, fire);
        else    chk("R4", "rt_fire per-thread", rt_fire, fire);
        @(posedge clk);
        if (fire) begin
            void'(m_seq[tgt].pop_front());
            void'(m_rdy[tgt].pop_front());
        end
        if (acc) begin
            m_seq[at].push_back(seq_ctr);
            m_rdy[at].push_back(ardy);
            seq_ctr++;
        end
        #2;
        check_state();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // fill: seq 1..8 alternate threads; seq 3 not ready
        for (int i = 0; i < CAP; i++) begin
            step(1, i % 2, seq_ctr != 3, 0, 0, 0);
            if (i == 0) chk("R3", "head after first alloc", ghead_seq, 1);
        end
        step(1, 0, 1, 0, 0, 0);
        chk("R2", "gtail_seq unchanged when full", gtail_seq, 8);
        chk("R2", "total stays at capacity", total_count, CAP);

        rd_tid = 1;
        step(0, 0, 1, 1, 1, 0);   // retires seq 1
        step(0, 0, 1, 1, 1, 0);   // retires seq 2
        step(0, 0, 1, 1, 1, 0);   // head seq 3 not ready
        chk("R4", "blocked head kept", ghead_seq, 3);
        step(0, 0, 1, 1, 0, 0);   // thread 0 front not ready
        step(0, 0, 1, 1, 0, 1);   // R12: thread 1 retires seq 4
        chk("R12", "thread1 front after retire", th_head_seq, 6);

        act_mask = 2'b01;
        step(0, 0, 1, 1, 1, 0);
        chk("R8", "masked ready thread ignored", can_commit, 0);
        act_mask = 2'b11;

        step(1, 0, 1, 1, 0, 1);   // both in one cycle
        chk("R11", "alloc+retire keeps total", total_count, 5);
        step(1, 1, 1, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0);
        chk("R2", "full again", full, 1);
        step(1, 1, 1, 1, 0, 1);
        chk("R11", "alloc at full dropped despite retire", total_count, CAP - 1);

        do_reset();
        for (int c = 0; c < 4000; c++) begin
            int unsigned r;
            if (c % 600 == 599) do_reset();
            r = rnd();
            act_mask = (r[2:0] == 0) ? NT'(r[4:3]) : '1;
            rd_tid = TW'(r[5]);
            step(r[6] | r[7], int'(r[8]), r[12:9] != 0,
                 r[13] | r[14], r[15], int'(r[16]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule